// File: doc/BRIEF.md
# 64-bit Integer Execute Unit with 32-bit Word Variants

This block is the arithmetic and logic stage of a 64-bit integer datapath. It receives two 64-bit operands, the program counter of the current instruction, a 4-bit operation code and a word-mode flag. From these it produces one 64-bit result in the same cycle. It holds no state. Operands arrive already selected by the surrounding pipeline, and any immediate is already extracted and sign-extended.

The unit implements addition, subtraction, the three shifts, the bitwise logic operations, signed and unsigned less-than, upper-immediate materialisation and pc-relative upper-immediate addition. When the word-mode flag is set on add, subtract or a shift, the operation uses only the low 32 bits of the operands. Its 32-bit result is then sign-extended, so that bits 63:32 always repeat bit 31. Compilers use this for the 32-bit integer type on a 64-bit machine.

Top module: `alu64_core`

## Requirements
- R1: With word mode clear, op 0 returns a+b and op 1 returns a-b, both modulo 2^64.
- R2: With word mode set, op 0 and op 1 form the 32-bit sum or difference of a[31:0] and b[31:0]. Overflow is discarded, bits 63:32 of both operands are ignored, and the 32-bit value is sign-extended to 64 bits.
- R3: With word mode clear, op 2 (left shift), op 3 (logical right shift) and op 4 (arithmetic right shift) shift a by b[5:0]. Bits 63:6 of b have no effect.
- R4: With word mode set, ops 2, 3 and 4 shift a[31:0] by b[4:0]. Bits 63:5 of b and bits 63:32 of a have no effect, and the 32-bit result is sign-extended to 64 bits.
- R5: The left shift fills vacated low bits with zero and the logical right shift fills vacated high bits with zero. The arithmetic right shift fills with bit 63 in full mode and with bit 31 in word mode.
- R6: Op 5 returns a AND b, op 6 returns a OR b and op 7 returns a XOR b.
- R7: Op 8 returns 1 when a is less than b as two's-complement numbers and 0 otherwise. Op 9 does the same for unsigned magnitudes. Bits 63:1 of the result are always zero.
- R8: Op 10 places b[19:0] into result bits 31:12 and clears bits 11:0. Bits 63:32 copy bit 31, and b[63:20] has no effect.
- R9: Op 11 returns pc plus the value op 10 would produce for the same b.
- R10: Word mode has no effect on ops 5 to 11. The result equals the full-width result.
- R11: Op codes 12 to 15 return zero.
- R12: A word-mode add with b equal to zero returns the sign-extension of a[31:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand (value to shift for shifts) |
| b_i | input | 64 | Second operand, shift amount or upper-immediate field |
| pc_i | input | 64 | Program counter of the current instruction |
| op_i | input | 4 | Operation code, encoding in R1 to R11 |
| word_i | input | 1 | Selects the 32-bit variant of add, subtract and shifts |
| res_o | output | 64 | Result |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and res_o. The bench therefore changes the inputs on a falling clock edge. It compares res_o a short settling delay later, well before the next rising edge, so each sample sees one complete input set. Shift amounts 0, 31, 32 and 63 are each applied with and without junk in the ignored high bits of b. A behavioural reference model built from language operators covers random operands for every op code in both modes.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_SLL   = 4'd2,
    OP_SRL   = 4'd3,
    OP_SRA   = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_XOR   = 4'd7,
    OP_SLT   = 4'd8,
    OP_SLTU  = 4'd9,
    OP_UPIMM = 4'd10,
    OP_PCREL = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

endpackage

// File: rtl/alu64_addsub.sv
module alu64_addsub #(
  parameter int XLEN    = 64,
  parameter int UIMM_W  = 20,
  parameter int UIMM_LO = 12
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic            lt_s_o,
  output logic            lt_u_o,
  output logic [XLEN-1:0] upimm_o,
  output logic [XLEN-1:0] pcrel_o
);
  localparam int UIMM_TOP = UIMM_LO + UIMM_W;
  localparam int EXT_W    = XLEN - UIMM_TOP;

  logic [XLEN-1:0] b_eff;
  logic [XLEN:0]   wide_sum;
  logic            carry_out;

  always_comb begin
    b_eff    = sub_i ? ~b_i : b_i;
    wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub_i};
    sum_o    = wide_sum[XLEN-1:0];
    carry_out = wide_sum[XLEN];
    // borrow occurs exactly when no carry leaves a + ~b + 1
    lt_u_o   = ~carry_out;
    lt_s_o   = (a_i[XLEN-1] != b_i[XLEN-1]) ? a_i[XLEN-1] : sum_o[XLEN-1];
  end

  always_comb begin
    upimm_o = {{EXT_W{b_i[UIMM_W-1]}}, b_i[UIMM_W-1:0], {UIMM_LO{1'b0}}};
    pcrel_o = pc_i + upimm_o;
  end

  // R7: operands with equal sign bits order identically signed and unsigned
  always_comb begin
    if (sub_i && (a_i[XLEN-1] == b_i[XLEN-1])) begin
      assert_slt_agree_R7: assert (lt_s_o == lt_u_o)
        else $error("signed and unsigned compare disagree on same-sign operands");
    end
  end

endmodule

// File: rtl/alu64_shifter.sv
module alu64_shifter #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0]         a_i,
  input  logic [$clog2(XLEN)-1:0] amt_i,
  input  logic                    left_i,
  input  logic                    arith_i,
  input  logic                    word_i,
  output logic [XLEN-1:0]         res_o
);
  localparam int SH_W = $clog2(XLEN);

  logic [XLEN-1:0] src;
  logic [XLEN-1:0] src_oriented;
  logic            fill;
  logic [XLEN-1:0] stage [SH_W+1];

  always_comb begin
    if (word_i) begin
      src = arith_i ? {{(XLEN-WLEN){a_i[WLEN-1]}}, a_i[WLEN-1:0]}
                    : {{(XLEN-WLEN){1'b0}},        a_i[WLEN-1:0]};
    end else begin
      src = a_i;
    end
    fill = arith_i & ~left_i & src[XLEN-1];
    for (int k = 0; k < XLEN; k++) begin
      src_oriented[k] = left_i ? src[XLEN-1-k] : src[k];
    end
    stage[0] = src_oriented;
  end

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int STEP = 1 << i;
    always_comb begin
      stage[i+1] = amt_i[i] ? {{STEP{fill}}, stage[i][XLEN-1:STEP]} : stage[i];
    end
  end

  always_comb begin
    for (int k = 0; k < XLEN; k++) begin
      res_o[k] = left_i ? stage[SH_W][XLEN-1-k] : stage[SH_W][k];
    end
  end

  // R3: a zero shift in full mode leaves the operand untouched
  always_comb begin
    if (!word_i && amt_i == '0) begin
      assert_zero_shift_R3: assert (res_o == a_i)
        else $error("zero-amount shift altered the operand");
    end
  end

endmodule

// File: rtl/alu64_logic.sv
module alu64_logic
  import alu64_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic_sel_e      sel_i,
  output logic [XLEN-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu64_core.sv
module alu64_core
  import alu64_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [3:0]      op_i,
  input  logic            word_i,
  output logic [XLEN-1:0] res_o
);
  localparam int SH_W  = $clog2(XLEN);
  localparam int WSH_W = $clog2(WLEN);

  alu_op_e         op;
  logic            word_ok;
  logic            use_sub;
  logic [SH_W-1:0] shamt;
  logic            sh_left;
  logic            sh_arith;
  logic_sel_e      lg_sel;
  logic [XLEN-1:0] sum;
  logic            lt_s;
  logic            lt_u;
  logic [XLEN-1:0] upimm;
  logic [XLEN-1:0] pcrel;
  logic [XLEN-1:0] sh_res;
  logic [XLEN-1:0] lg_res;
  logic [XLEN-1:0] full_res;

  always_comb begin
    op       = alu_op_e'(op_i);
    word_ok  = word_i && (op inside {OP_ADD, OP_SUB, OP_SLL, OP_SRL, OP_SRA});
    use_sub  = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
    shamt    = word_ok ? {{(SH_W-WSH_W){1'b0}}, b_i[WSH_W-1:0]} : b_i[SH_W-1:0];
    sh_left  = (op == OP_SLL);
    sh_arith = (op == OP_SRA);
    case (op)
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_AND;
    endcase
  end

  alu64_addsub #(.XLEN(XLEN)) u_addsub (
    .a_i     (a_i),
    .b_i     (b_i),
    .pc_i    (pc_i),
    .sub_i   (use_sub),
    .sum_o   (sum),
    .lt_s_o  (lt_s),
    .lt_u_o  (lt_u),
    .upimm_o (upimm),
    .pcrel_o (pcrel)
  );

  alu64_shifter #(.XLEN(XLEN), .WLEN(WLEN)) u_shift (
    .a_i     (a_i),
    .amt_i   (shamt),
    .left_i  (sh_left),
    .arith_i (sh_arith),
    .word_i  (word_ok),
    .res_o   (sh_res)
  );

  alu64_logic #(.XLEN(XLEN)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (lg_sel),
    .res_o (lg_res)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:         full_res = sum;
      OP_SLL, OP_SRL, OP_SRA: full_res = sh_res;
      OP_AND, OP_OR, OP_XOR:  full_res = lg_res;
      OP_SLT:                 full_res = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU:                full_res = {{(XLEN-1){1'b0}}, lt_u};
      OP_UPIMM:               full_res = upimm;
      OP_PCREL:               full_res = pcrel;
      default:                full_res = '0;
    endcase
    res_o = word_ok ? {{(XLEN-WLEN){full_res[WLEN-1]}}, full_res[WLEN-1:0]} : full_res;
  end

  always_comb begin
    // R2 / R4: word results carry bit 31 through the upper half
    if (word_ok) begin
      assert_word_sext_R4: assert (res_o[XLEN-1:WLEN] == {(XLEN-WLEN){res_o[WLEN-1]}})
        else $error("word-mode result not sign-extended");
    end
    // R7: compares yield a single flag bit
    if (op == OP_SLT || op == OP_SLTU) begin
      assert_flag_width_R7: assert (res_o[XLEN-1:1] == '0)
        else $error("compare result wider than one bit");
    end
    // R8: upper-immediate clears the low twelve bits
    if (op == OP_UPIMM) begin
      assert_upimm_low_R8: assert (res_o[11:0] == '0)
        else $error("upper-immediate low bits not clear");
    end
    // R4: a zero word shift equals the sign-extended low word of a
    if (word_ok && (op == OP_SRL || op == OP_SLL) && b_i[WSH_W-1:0] == '0) begin
      assert_word_zero_shift_R4: assert (res_o[WLEN-1:0] == a_i[WLEN-1:0])
        else $error("zero word shift altered the low word");
    end
  end

endmodule

// File: tb/sim_alu64_core.sv
module sim_alu64_core;

  logic        clk;
  logic        rst_n;
  logic [63:0] a, b, pc;
  logic [3:0]  op;
  logic        word;
  logic [63:0] res;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  alu64_core u0 (
    .a_i    (a),
    .b_i    (b),
    .pc_i   (pc),
    .op_i   (op),
    .word_i (word),
    .res_o  (res)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] model(input logic [3:0] o, input logic [63:0] x,
                                        input logic [63:0] y, input logic [63:0] p,
                                        input logic w);
    logic [63:0] up;
    logic [31:0] lw;
    up = {{32{y[19]}}, y[19:0], 12'h000};
    if (w && o <= 4'd4) begin
      case (o)
        4'd0: lw = x[31:0] + y[31:0];
        4'd1: lw = x[31:0] - y[31:0];
        4'd2: lw = x[31:0] << y[4:0];
        4'd3: lw = x[31:0] >> y[4:0];
        default: lw = $signed(x[31:0]) >>> y[4:0];
      endcase
      return sx32(lw);
    end
    case (o)
      4'd0:  return x + y;
      4'd1:  return x - y;
      4'd2:  return x << y[5:0];
      4'd3:  return x >> y[5:0];
      4'd4:  return $signed(x) >>> y[5:0];
      4'd5:  return x & y;
      4'd6:  return x | y;
      4'd7:  return x ^ y;
      4'd8:  return ($signed(x) < $signed(y)) ? 64'd1 : 64'd0;
      4'd9:  return (x < y) ? 64'd1 : 64'd0;
      4'd10: return up;
      4'd11: return p + up;
      default: return 64'd0;
    endcase
  endfunction

  task automatic drive(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y,
                       input logic [63:0] p, input logic w);
    @(negedge clk);
    op = o; a = x; b = y; pc = p; word = w;
    #2;
  endtask

  task automatic chk(input string tag, input logic [63:0] exp);
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s: op=%0d word=%0b a=%h b=%h got %h expected %h",
               tag, op, word, a, b, res, exp);
    end
  endtask

  task automatic t_reset;
    drive(4'd0, 64'd0, 64'd0, 64'd0, 1'b0);
    chk("R1 idle after reset", 64'd0);
  endtask

  task automatic t_addsub;
    drive(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 1'b0);
    chk("R1 add wrap", 64'd0);
    drive(4'd1, 64'd0, 64'd1, 0, 1'b0);
    chk("R1 sub borrow", 64'hFFFF_FFFF_FFFF_FFFF);
    drive(4'd0, 64'h1234_5678_7FFF_FFFF, 64'hABCD_0000_0000_0001, 0, 1'b1);
    chk("R2 word add overflow", 64'hFFFF_FFFF_8000_0000);
    drive(4'd1, 64'hFFFF_FFFF_0000_0000, 64'd1, 0, 1'b1);
    chk("R2 word sub upper ignored", 64'hFFFF_FFFF_FFFF_FFFF);
    drive(4'd0, 64'hDEAD_BEEF_8000_0123, 64'd0, 0, 1'b1);
    chk("R12 word add zero", 64'hFFFF_FFFF_8000_0123);
    drive(4'd0, 64'h8000_0000_7654_3210, 64'd0, 0, 1'b1);
    chk("R12 word add zero positive", 64'h0000_0000_7654_3210);
  endtask

  task automatic t_shift_corners;
    logic [63:0] pat;
    pat = 64'hC3A5_0F96_8421_7E5B;
    foreach (pat[i]) begin end
    for (int s = 0; s < 4; s++) begin
      logic [5:0] amt;
      amt = (s == 0) ? 6'd0 : (s == 1) ? 6'd31 : (s == 2) ? 6'd32 : 6'd63;
      for (int o = 2; o <= 4; o++) begin
        drive(4'(o), pat, {58'h0, amt}, 0, 1'b0);
        chk("R3 full shift", model(4'(o), pat, {58'h0, amt}, 0, 1'b0));
        drive(4'(o), pat, {58'h3FF_FFFF_FFFF_FFF5, amt}, 0, 1'b0);
        chk("R3 full shift junk high amount", model(4'(o), pat, {58'h0, amt}, 0, 1'b0));
        drive(4'(o), pat, {58'h0, amt}, 0, 1'b1);
        chk("R4 word shift", model(4'(o), pat, {59'h0, amt[4:0]}, 0, 1'b1));
        drive(4'(o), {~pat[63:32], pat[31:0]}, {58'h2AA_AAAA_AAAA_AAAA, amt}, 0, 1'b1);
        chk("R4 word shift junk upper", model(4'(o), pat, {59'h0, amt[4:0]}, 0, 1'b1));
      end
    end
  endtask

  task automatic t_fill;
    drive(4'd4, 64'h8000_0000_0000_0000, 64'd63, 0, 1'b0);
    chk("R5 full sra fills bit 63", 64'hFFFF_FFFF_FFFF_FFFF);
    drive(4'd3, 64'h8000_0000_0000_0000, 64'd63, 0, 1'b0);
    chk("R5 full srl fills zero", 64'd1);
    drive(4'd4, 64'h0000_0000_8000_0000, 64'd31, 0, 1'b1);
    chk("R5 word sra fills bit 31", 64'hFFFF_FFFF_FFFF_FFFF);
    drive(4'd4, 64'h8000_0000_0000_0000, 64'd4, 0, 1'b1);
    chk("R5 word sra ignores bit 63", 64'd0);
    drive(4'd3, 64'hFFFF_FFFF_8000_0000, 64'd1, 0, 1'b1);
    chk("R5 word srl zero fill", 64'h0000_0000_4000_0000);
    drive(4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd4, 0, 1'b0);
    chk("R5 sll zero fill", 64'hFFFF_FFFF_FFFF_FFF0);
  endtask

  task automatic t_logic_cmp;
    drive(4'd5, 64'hF0F0_F0F0_0F0F_0F0F, 64'hFF00_FF00_FF00_FF00, 0, 1'b0);
    chk("R6 and", 64'hF000_F000_0F00_0F00);
    drive(4'd6, 64'hF0F0_F0F0_0F0F_0F0F, 64'hFF00_FF00_FF00_FF00, 0, 1'b0);
    chk("R6 or", 64'hFFF0_FFF0_FF0F_FF0F);
    drive(4'd7, 64'hF0F0_F0F0_0F0F_0F0F, 64'hFF00_FF00_FF00_FF00, 0, 1'b0);
    chk("R6 xor", 64'h0FF0_0FF0_F00F_F00F);
    drive(4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 1'b0);
    chk("R7 slt negative", 64'd1);
    drive(4'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 1'b0);
    chk("R7 sltu large", 64'd0);
    drive(4'd8, 64'd5, 64'd5, 0, 1'b0);
    chk("R7 slt equal", 64'd0);
  endtask

  task automatic t_upper;
    drive(4'd10, 0, 64'h0000_0000_0008_0000, 0, 1'b0);
    chk("R8 upper imm negative", 64'hFFFF_FFFF_8000_0000);
    drive(4'd10, 0, 64'hFFFF_FFFF_FFF1_2345, 0, 1'b0);
    chk("R8 upper imm ignores b high", 64'h0000_0000_1234_5000);
    drive(4'd11, 0, 64'h0000_0000_000F_FFFF, 64'h1000, 1'b0);
    chk("R9 pc relative", 64'd0);
    drive(4'd11, 0, 64'h0000_0000_0000_0001, 64'h0000_0001_0000_0000, 1'b0);
    chk("R9 pc relative up", 64'h0000_0001_0000_1000);
  endtask

  task automatic t_word_ignored;
    for (int o = 5; o <= 11; o++) begin
      drive(4'(o), 64'h8765_4321_F0E1_D2C3, 64'h0123_4567_89AB_CDEF, 64'h4000, 1'b1);
      chk("R10 word flag ignored",
          model(4'(o), 64'h8765_4321_F0E1_D2C3, 64'h0123_4567_89AB_CDEF, 64'h4000, 1'b0));
    end
    for (int o = 12; o <= 15; o++) begin
      drive(4'(o), 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h10, 1'b0);
      chk("R11 unassigned op", 64'd0);
    end
  endtask

  task automatic t_random;
    for (int n = 0; n < 600; n++) begin
      logic [3:0]  o;
      logic [63:0] x, y, p;
      logic        w;
      o = 4'($urandom_range(0, 11));
      w = 1'($urandom);
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      p = {$urandom, $urandom};
      if (n % 5 == 0) y = x;
      drive(o, x, y, p, w);
      chk("R1 R2 R3 R4 R6 R7 R8 R9 R10 random vs model", model(o, x, y, p, w));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    op = 4'd0; a = '0; b = '0; pc = '0; word = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_addsub();
    t_shift_corners();
    t_fill();
    t_logic_cmp();
    t_upper();
    t_word_ignored();
    t_random();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule